// File: doc/BRIEF.md
# Segment Descriptor Privilege Checker

This block judges whether loading a segment register is legal. It applies the rules to a 16-bit selector and an already fetched 64-bit descriptor, together with the current privilege level and a flag for 64-bit mode. Fetching the descriptor and updating the segment cache are left to neighbouring logic.

Two rule sets are supported. The first is the stack-segment load check. The second is the check on the code segment that is the target of a far return. Each request is a single input strobe. One clock later the block returns a one-cycle result holding a pass flag, a fault class and a 16-bit error code. Faults are weighed in a fixed priority: every general-protection condition is tested before the present bit.

The interface has no back-pressure. A request is accepted on every cycle in which `in_valid` is high. The result is presented for exactly one cycle, and the consumer must take it then. Requests may be issued back to back.

Top module: `segchk_top`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the following cycle only. Whenever `out_valid` is low, `out_pass`, `out_illegal`, `out_fault` and `out_err` are all zero.
- R2: Field and code layout:
  - Selector: RPL is bits [1:0], table indicator is bit 2, index is bits [15:3]. A selector is null when bits [15:2] are all zero.
  - Descriptor: present bit 47, DPL bits [46:45], S bit 44, code bit 43, conforming bit 42, writable bit 41.
  - Check type: 00 is stack, 01 is return.
  - Fault class: 00 none, 01 general protection, 10 stack fault, 11 not present.
- R3: Stack check, null selector: the result is a pass when `in_long_mode` is 1 and the CPL is not 3. Otherwise it is a general-protection fault.
- R4: Stack check, non-null selector: the descriptor must have S=1, code=0 and writable=1, and both its DPL and the RPL must equal the CPL. If any of these fails, the result is a general-protection fault.
- R5: Stack check, non-null selector: a descriptor that meets R4 but has present=0 gives a stack fault.
- R6: Return check: a null selector, or an RPL numerically below the CPL, gives a general-protection fault.
- R7: Return check: a descriptor without both S=1 and code=1 gives a general-protection fault.
- R8: Return check, code segment:
  - Non-conforming (conforming bit 0): DPL must equal RPL.
  - Conforming: DPL must not exceed RPL.
  - A violation of either gives a general-protection fault.
- R9: Return check: when present=0 and some general-protection condition also holds, the result is general protection. Otherwise present=0 gives not-present.
- R10: `out_err` carries the full selector on a general-protection fault, and zero on a pass or on any other fault.
- R11: Check types 10 and 11 raise `out_illegal` with pass 0, fault class none and error code zero.
- R12: `out_pass` is high exactly when the result is valid, the check type is supported and the fault class is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_chk | input | 2 | Check type |
| in_sel | input | 16 | Segment selector |
| in_desc | input | 64 | Fetched descriptor |
| in_cpl | input | 2 | Current privilege level |
| in_long_mode | input | 1 | Processor is in 64-bit mode |
| out_valid | output | 1 | Result strobe, one cycle |
| out_pass | output | 1 | Load is legal |
| out_fault | output | 2 | Fault class |
| out_err | output | 16 | Error code |
| out_illegal | output | 1 | Unsupported check type |

## Verification
Every result is due on the clock edge right after its request, and it is gone on the edge after that. The bench drives a request on a falling edge and reads all outputs on the next falling edge, half a period after the registering edge. Then, with the strobe dropped and the other inputs scrambled, it reads them once more to confirm the idle zeros. Random requests, skewed toward null selectors, matching privilege levels and code or writable-data types, are mixed with directed priority cases and compared with a bench model built from the requirements.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int PL_W   = 2;

  localparam int D_PRESENT  = 47;
  localparam int D_DPL_LO   = 45;
  localparam int D_SYS_N    = 44;
  localparam int D_CODE     = 43;
  localparam int D_CONFORM  = 42;
  localparam int D_WRITABLE = 41;

  localparam logic [1:0] CHK_STACK  = 2'b00;
  localparam logic [1:0] CHK_RETURN = 2'b01;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_GP     = 2'b01,
    FLT_STACK  = 2'b10,
    FLT_ABSENT = 2'b11
  } fault_e;

  typedef struct packed {
    logic            is_null;
    logic            table_ind;
    logic [PL_W-1:0] rpl;
  } sel_view_t;

  typedef struct packed {
    logic            present;
    logic [PL_W-1:0] dpl;
    logic            user_seg;
    logic            is_code;
    logic            conform;
    logic            writable;
  } desc_view_t;

endpackage

// File: rtl/segchk_decode.sv
module segchk_decode
  import segchk_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int DW = DESC_W
) (
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] desc,
  output sel_view_t     sv,
  output desc_view_t    dv
);
  localparam int IDX_LO = PL_W;

  always_comb begin
    sv.rpl       = sel[PL_W-1:0];
    sv.table_ind = sel[IDX_LO];
    sv.is_null   = (sel[SW-1:IDX_LO] == '0);
    dv.present   = desc[D_PRESENT];
    dv.dpl       = desc[D_DPL_LO +: PL_W];
    dv.user_seg  = desc[D_SYS_N];
    dv.is_code   = desc[D_CODE];
    dv.conform   = desc[D_CONFORM];
    dv.writable  = desc[D_WRITABLE];
  end
endmodule

// File: rtl/segchk_stack_rules.sv
module segchk_stack_rules
  import segchk_pkg::*;
(
  input  sel_view_t       sv,
  input  desc_view_t      dv,
  input  logic [PL_W-1:0] cpl,
  input  logic            long_mode,
  output fault_e          fault
);
  localparam logic [PL_W-1:0] USER_PL = '1;

  logic good_type;
  logic pl_match;

  always_comb begin
    good_type = dv.user_seg && !dv.is_code && dv.writable;
    pl_match  = (dv.dpl == cpl) && (sv.rpl == cpl);
    if (sv.is_null) begin
      fault = (long_mode && (cpl != USER_PL)) ? FLT_NONE : FLT_GP;
    end else if (!good_type || !pl_match) begin
      fault = FLT_GP;
    end else if (!dv.present) begin
      fault = FLT_STACK;
    end else begin
      fault = FLT_NONE;
    end
  end

  // Stack fault only for a non-null selector whose descriptor is absent.
  always_comb begin
    if (fault == FLT_STACK) begin
      p_stack_fault_absent_r5: assert (!sv.is_null && !dv.present);
    end
  end
endmodule

// File: rtl/segchk_return_rules.sv
module segchk_return_rules
  import segchk_pkg::*;
(
  input  sel_view_t       sv,
  input  desc_view_t      dv,
  input  logic [PL_W-1:0] cpl,
  output fault_e          fault
);
  logic bad_sel;
  logic bad_type;
  logic bad_dpl;

  always_comb begin
    bad_sel  = sv.is_null || (sv.rpl < cpl);
    bad_type = !(dv.user_seg && dv.is_code);
    bad_dpl  = dv.conform ? (dv.dpl > sv.rpl) : (dv.dpl != sv.rpl);
    if (bad_sel || bad_type || bad_dpl) begin
      fault = FLT_GP;
    end else if (!dv.present) begin
      fault = FLT_ABSENT;
    end else begin
      fault = FLT_NONE;
    end
  end

  // Not-present is reported only for a descriptor whose present bit is clear.
  always_comb begin
    if (fault == FLT_ABSENT) begin
      p_absent_after_gp_r9: assert (!dv.present && !sv.is_null);
    end
  end
endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int DW = DESC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_chk,
  input  logic [SW-1:0]   in_sel,
  input  logic [DW-1:0]   in_desc,
  input  logic [PL_W-1:0] in_cpl,
  input  logic            in_long_mode,
  output logic            out_valid,
  output logic            out_pass,
  output logic [1:0]      out_fault,
  output logic [SW-1:0]   out_err,
  output logic            out_illegal
);
  sel_view_t  sv;
  desc_view_t dv;
  fault_e     stk_fault;
  fault_e     ret_fault;
  fault_e     pick_fault;
  fault_e     nxt_fault;
  logic       chk_ok;
  logic       nxt_pass;
  logic [SW-1:0] nxt_err;

  segchk_decode #(.SW(SW), .DW(DW)) u_decode (
    .sel  (in_sel),
    .desc (in_desc),
    .sv   (sv),
    .dv   (dv)
  );

  segchk_stack_rules u_stack (
    .sv        (sv),
    .dv        (dv),
    .cpl       (in_cpl),
    .long_mode (in_long_mode),
    .fault     (stk_fault)
  );

  segchk_return_rules u_return (
    .sv    (sv),
    .dv    (dv),
    .cpl   (in_cpl),
    .fault (ret_fault)
  );

  always_comb begin
    chk_ok     = (in_chk == CHK_STACK) || (in_chk == CHK_RETURN);
    pick_fault = (in_chk == CHK_STACK) ? stk_fault : ret_fault;
    nxt_fault  = chk_ok ? pick_fault : FLT_NONE;
    nxt_pass   = chk_ok && (pick_fault == FLT_NONE);
    nxt_err    = (nxt_fault == FLT_GP) ? in_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pass    <= 1'b0;
      out_fault   <= FLT_NONE;
      out_err     <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pass    <= nxt_pass;
        out_fault   <= nxt_fault;
        out_err     <= nxt_err;
        out_illegal <= !chk_ok;
      end else begin
        out_pass    <= 1'b0;
        out_fault   <= FLT_NONE;
        out_err     <= '0;
        out_illegal <= 1'b0;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_pass && !out_illegal && out_fault == FLT_NONE && out_err == '0));
  p_gp_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_fault != FLT_GP || out_err == $past(in_sel)));
  p_pass_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_pass |-> (out_valid && out_fault == FLT_NONE && !out_illegal));
  p_illegal_type_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chk[1]) |=> (out_illegal && !out_pass));
  p_null_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chk == CHK_RETURN && in_sel[SW-1:PL_W] == '0) |=> out_fault == FLT_GP);
endmodule

// File: tb/tb_segchk_top.sv
module tb_segchk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_chk = 2'b00;
  logic [15:0] in_sel = 16'h0;
  logic [63:0] in_desc = 64'h0;
  logic [1:0]  in_cpl = 2'b00;
  logic        in_long_mode = 1'b0;
  logic        out_valid;
  logic        out_pass;
  logic [1:0]  out_fault;
  logic [15:0] out_err;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  segchk_top dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_chk       (in_chk),
    .in_sel       (in_sel),
    .in_desc      (in_desc),
    .in_cpl       (in_cpl),
    .in_long_mode (in_long_mode),
    .out_valid    (out_valid),
    .out_pass     (out_pass),
    .out_fault    (out_fault),
    .out_err      (out_err),
    .out_illegal  (out_illegal)
  );

  // {illegal, pass, fault[1:0], err[15:0]}
  function automatic logic [19:0] model(input logic [1:0] chk, input logic [15:0] sel,
                                        input logic [63:0] d, input logic [1:0] cpl,
                                        input logic lm);
    logic nul;
    logic gp;
    logic [1:0] f;
    nul = (sel[15:2] == 14'd0);
    if (chk[1]) return {1'b1, 1'b0, 2'd0, 16'd0};
    if (chk == 2'b00) begin
      if (nul) gp = !(lm && cpl != 2'd3);
      else gp = !(d[44] && !d[43] && d[41]) || d[46:45] != cpl || sel[1:0] != cpl;
      f = gp ? 2'd1 : ((!nul && !d[47]) ? 2'd2 : 2'd0);
    end else begin
      gp = nul || sel[1:0] < cpl || !d[44] || !d[43] ||
           (d[42] ? (d[46:45] > sel[1:0]) : (d[46:45] != sel[1:0]));
      f = gp ? 2'd1 : (!d[47] ? 2'd3 : 2'd0);
    end
    return {1'b0, f == 2'd0, f, (f == 2'd1) ? sel : 16'd0};
  endfunction

  function automatic logic [63:0] mk_desc(input logic p, input logic [1:0] dpl,
                                          input logic s, input logic [3:0] typ);
    return {16'h00cf, p, dpl, s, typ, 40'h00_0000_ffff};
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%05h exp=%05h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input string tag, input logic [1:0] chk, input logic [15:0] sel,
                         input logic [63:0] d, input logic [1:0] cpl, input logic lm);
    @(negedge clk);
    in_valid = 1'b1; in_chk = chk; in_sel = sel; in_desc = d; in_cpl = cpl; in_long_mode = lm;
    @(negedge clk);
    check(tag, {out_illegal, out_pass, out_fault, out_err}, model(chk, sel, d, cpl, lm));
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R1 %s out_valid got=%b exp=1", tag, out_valid);
    end
    in_valid = 1'b0; in_chk = 2'($urandom); in_sel = 16'($urandom);
    in_desc = {$urandom, $urandom}; in_cpl = 2'($urandom); in_long_mode = 1'($urandom);
    @(negedge clk);
    check("R1 idle zeros", {out_valid, out_illegal, out_pass, out_fault, out_err[14:0]}, 20'd0);
    checks++;
    if (out_err !== 16'd0) begin
      errors++;
      $display("FAIL R1 idle err got=%04h exp=0000", out_err);
    end
  endtask

  localparam logic [3:0] T_DATA_RW = 4'b0010;
  localparam logic [3:0] T_DATA_RO = 4'b0000;
  localparam logic [3:0] T_CODE_NC = 4'b1010;
  localparam logic [3:0] T_CODE_CF = 4'b1110;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", {out_valid, out_illegal, out_pass, out_fault, out_err[14:0]}, 20'd0);
    rst_n = 1'b1;

    // R3 null stack selector
    run_vec("R3 null stack 64-bit cpl0 passes", 2'b00, 16'h0000, 64'h0, 2'd0, 1'b1);
    run_vec("R3 null stack legacy mode GP", 2'b00, 16'h0002, 64'h0, 2'd2, 1'b0);
    run_vec("R3 null stack 64-bit cpl3 GP", 2'b00, 16'h0003, 64'h0, 2'd3, 1'b1);
    // R4 stack descriptor rules
    run_vec("R4 stack writable data passes", 2'b00, 16'h0010, mk_desc(1, 0, 1, T_DATA_RW), 2'd0, 1'b0);
    run_vec("R4 stack read-only GP R10", 2'b00, 16'h0013, mk_desc(1, 3, 1, T_DATA_RO), 2'd3, 1'b0);
    run_vec("R4 stack dpl mismatch GP", 2'b00, 16'h0021, mk_desc(1, 0, 1, T_DATA_RW), 2'd1, 1'b0);
    run_vec("R4 stack rpl mismatch GP", 2'b00, 16'h0022, mk_desc(1, 1, 1, T_DATA_RW), 2'd1, 1'b0);
    run_vec("R4 stack code seg GP", 2'b00, 16'h0018, mk_desc(1, 0, 1, T_CODE_NC), 2'd0, 1'b0);
    // R5 presence
    run_vec("R5 stack absent gives stack fault R10", 2'b00, 16'h002a, mk_desc(0, 2, 1, T_DATA_RW), 2'd2, 1'b1);
    run_vec("R5 stack absent but read-only GP", 2'b00, 16'h002a, mk_desc(0, 2, 1, T_DATA_RO), 2'd2, 1'b1);
    // R6 return selector
    run_vec("R6 return null GP", 2'b01, 16'h0001, mk_desc(1, 1, 1, T_CODE_NC), 2'd0, 1'b0);
    run_vec("R6 return rpl below cpl GP", 2'b01, 16'h0031, mk_desc(1, 1, 1, T_CODE_NC), 2'd2, 1'b0);
    // R7 type
    run_vec("R7 return data seg GP", 2'b01, 16'h0033, mk_desc(1, 3, 1, T_DATA_RW), 2'd0, 1'b0);
    run_vec("R7 return system seg GP", 2'b01, 16'h0033, mk_desc(1, 3, 0, T_CODE_NC), 2'd0, 1'b0);
    // R8 dpl rules
    run_vec("R8 nonconforming dpl==rpl passes", 2'b01, 16'h0042, mk_desc(1, 2, 1, T_CODE_NC), 2'd1, 1'b0);
    run_vec("R8 nonconforming dpl<rpl GP", 2'b01, 16'h0043, mk_desc(1, 1, 1, T_CODE_NC), 2'd0, 1'b0);
    run_vec("R8 conforming dpl<rpl passes", 2'b01, 16'h0043, mk_desc(1, 1, 1, T_CODE_CF), 2'd0, 1'b0);
    run_vec("R8 conforming dpl>rpl GP", 2'b01, 16'h0041, mk_desc(1, 2, 1, T_CODE_CF), 2'd0, 1'b0);
    // R9 priority
    run_vec("R9 return absent gives not-present", 2'b01, 16'h0050, mk_desc(0, 0, 1, T_CODE_NC), 2'd0, 1'b1);
    run_vec("R9 absent with bad dpl GP first", 2'b01, 16'h0050, mk_desc(0, 3, 1, T_CODE_NC), 2'd0, 1'b1);
    // R11 unsupported type
    run_vec("R11 type 2 illegal", 2'b10, 16'h0010, mk_desc(1, 0, 1, T_DATA_RW), 2'd0, 1'b0);
    run_vec("R11 type 3 illegal", 2'b11, 16'h0000, 64'h0, 2'd3, 1'b0);

    // R12 random mix, R2 layout exercised throughout
    for (int i = 0; i < 1500; i++) begin
      logic [1:0]  c;
      logic [15:0] s;
      logic [63:0] d;
      logic [1:0]  pl;
      pl = 2'($urandom);
      c  = ($urandom % 10 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
      s  = 16'($urandom);
      if ($urandom % 6 == 0) s[15:2] = '0;
      if ($urandom % 2 == 0) s[1:0] = pl;
      d = {$urandom, $urandom};
      if ($urandom % 4 != 0) d[47] = 1'b1;
      if ($urandom % 4 != 0) d[44] = 1'b1;
      if ($urandom % 2 == 0) d[46:45] = pl;
      if ($urandom % 2 == 0) d[43:41] = (c == 2'b00) ? 3'b001 : {1'b1, 1'($urandom), 1'b1};
      run_vec("R12 random", c, s, d, pl, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule